// File: doc/BRIEF.md
# Colour LCD Controller Register Interface

This block is the register front end of a colour LCD controller. It sits on a simple 32-bit peripheral bus and decodes a 4 KB window. It holds four timing words, the base addresses of the upper and lower frame buffers, a control word, an interrupt mask and a sticky raw interrupt status. From these it drives the configuration outputs that the pixel fetch and timing logic use.

The active column and row counts are computed from packed fields of the first two timing words. The enable output is high only when both the enable bit and the power bit of the control word are set. Reads of a fixed window return identification bytes. Accesses to the palette window are passed to an external palette store through a strobe, an index and a data path.

A parameter selects one of two register maps. The only difference between them is which of two word offsets holds the control word and which holds the interrupt mask. The identification bytes also differ between the two maps.

Top module: `lcdc_regs`

## Requirements
- R1: After reset, every register is zero. After reset, `bus_rdata`, `bus_err`, `irq` and `lcd_on` are 0, `active_cols` is 16 and `active_rows` is 1.
- R2: Word offsets (address bits [11:2]) 0 to 3 are four 32-bit read/write timing words. Offset 4 is the upper base and offset 5 is the lower base, and `upper_base`/`lower_base` show these two words. Read data appears on `bus_rdata` in the cycle after the access edge. In every other cycle `bus_rdata` is zero.
- R3: With `ALT_MAP`=0, offset 6 is the interrupt mask and offset 7 is the control word. With `ALT_MAP`=1 the two are swapped, for both reads and writes.
- R4: `active_cols` = ((timing0 & 0xFC) + 4) * 4, which ranges from 16 to 1024. `active_rows` = (timing1 & 0x3FF) + 1, which ranges from 1 to 1024.
- R5: `lcd_on` = control bit 0 AND control bit 11. `depth_mode` = control bits [3:1]. `bgr_order` = bit 8, `be_bytes` = bit 9 and `be_pixels` = bit 10.
- R6: A high bit of `irq_evt` sets the matching raw status bit, and that bit stays set. Offset 8 reads the raw status and offset 9 reads raw AND mask, both zero-extended. `irq` is the OR of the masked bits.
- R7: A write to offset 10 clears every raw bit that is 1 in the written value. An event on the same edge wins, so the bit stays set. A read of offset 10 returns zero and raises no error.
- R8: Offsets 11 and 12 read back the upper and lower base. Writes to offsets 8, 9, 11 and 12 change nothing.
- R9: Byte addresses 0xFE0 to 0xFFF return identification byte k = address[4:2], zero-extended. For `ALT_MAP`=0 the bytes for k=0..7 are 3A 1C 02 00 E5 7D 90 4B. For `ALT_MAP`=1 they are 3B 1C 22 00 E5 7D 90 4B. Writes to this window are ignored.
- R10: Byte addresses 0x200 to 0x3FF raise `pal_sel` in the access cycle. In that cycle `pal_we` = `bus_we`, `pal_idx` = address[8:2] and `pal_wdata` = `bus_wdata`. A read returns the `pal_rdata` present in the access cycle.
- R11: Any other address is undefined (word offsets 13 to 127, and 0x400 to 0xFDF). A read there returns zero and a write changes nothing. `bus_err` is high for exactly the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an undefined access |
| irq_evt | input | NIRQ | Interrupt event inputs |
| pal_sel | output | 1 | Palette window access |
| pal_we | output | 1 | Palette write |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data |
| irq | output | 1 | OR of masked status |
| lcd_on | output | 1 | Enable and power both set |
| depth_mode | output | 3 | Pixel depth code |
| bgr_order | output | 1 | Blue/red swap |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order |
| active_cols | output | 11 | Derived column count |
| active_rows | output | 11 | Derived row count |
| upper_base | output | 32 | Upper frame base |
| lower_base | output | 32 | Lower frame base |

## Verification
The bench drives two instances, one of each map, from the same bus. This way a decoder that ignores the variant writes the mask where the control word belongs, and the two instances then disagree on `lcd_on` and `irq`. Directed cases cover the extremes of both geometry fields. A design that masked the wrong bits or dropped the +1 would report 0 or 1023 rows. Other directed cases give each control bit alone, so that a missing power term turns the display on. A clear is issued on the same edge as an event, and a design that lets the clear win loses that interrupt. Writes to read-only and undefined offsets are followed by reads and output checks, which catch corrupted state and a missing or stretched error pulse.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int DW       = 32;
    localparam int AW       = 12;
    localparam int WORD_W   = AW - 2;
    localparam int PAL_IW   = 7;
    localparam int ID_IW    = 3;
    localparam int COLF_W   = 6;
    localparam int ROWF_W   = 10;
    localparam int GEO_W    = 11;

    localparam int CTL_EN    = 0;
    localparam int CTL_DLSB  = 1;
    localparam int CTL_BGR   = 8;
    localparam int CTL_BEB   = 9;
    localparam int CTL_BEP   = 10;
    localparam int CTL_PWR   = 11;

    typedef enum logic [3:0] {
        KIND_NONE,
        KIND_TIMING,
        KIND_UPBASE,
        KIND_LPBASE,
        KIND_MASK,
        KIND_CTRL,
        KIND_RAW,
        KIND_MASKED,
        KIND_CLEAR,
        KIND_UPCUR,
        KIND_LPCUR,
        KIND_PAL,
        KIND_ID
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [ID_IW-1:0]   sub;
    } acc_dec_t;

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
#(
    parameter bit ALT_MAP = 1'b0
) (
    input  logic [WORD_W-1:0] word,
    output acc_dec_t          dec
);

    localparam acc_kind_e KIND_AT6 = ALT_MAP ? KIND_CTRL : KIND_MASK;
    localparam acc_kind_e KIND_AT7 = ALT_MAP ? KIND_MASK : KIND_CTRL;

    always_comb begin
        dec.sub  = word[ID_IW-1:0];
        dec.kind = KIND_NONE;
        if (word[WORD_W-1:WORD_W-3] == 3'b001) begin
            dec.kind = KIND_PAL;
        end else if (word[WORD_W-1:ID_IW] == '1) begin
            dec.kind = KIND_ID;
        end else begin
            case (word)
                10'd0, 10'd1, 10'd2, 10'd3: dec.kind = KIND_TIMING;
                10'd4:   dec.kind = KIND_UPBASE;
                10'd5:   dec.kind = KIND_LPBASE;
                10'd6:   dec.kind = KIND_AT6;
                10'd7:   dec.kind = KIND_AT7;
                10'd8:   dec.kind = KIND_RAW;
                10'd9:   dec.kind = KIND_MASKED;
                10'd10:  dec.kind = KIND_CLEAR;
                10'd11:  dec.kind = KIND_UPCUR;
                10'd12:  dec.kind = KIND_LPCUR;
                default: dec.kind = KIND_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lcdc_geometry.sv
module lcdc_geometry
    import lcdc_pkg::*;
(
    input  logic [COLF_W-1:0] col_field,
    input  logic [ROWF_W-1:0] row_field,
    output logic [GEO_W-1:0]  cols,
    output logic [GEO_W-1:0]  rows
);

    localparam int CSUM_W = COLF_W + 1;

    logic [CSUM_W-1:0] col_units;

    always_comb begin
        col_units = CSUM_W'(col_field) + CSUM_W'(1);
        cols      = {col_units, 4'b0000};
        rows      = GEO_W'(row_field) + GEO_W'(1);
    end

endmodule

// File: rtl/lcdc_id_rom.sv
module lcdc_id_rom
    import lcdc_pkg::*;
#(
    parameter bit ALT_MAP = 1'b0
) (
    input  logic [ID_IW-1:0] idx,
    output logic [7:0]       id_byte
);

    logic [7:0] tail_byte;

    always_comb begin
        case (idx)
            3'd3:    tail_byte = 8'h00;
            3'd4:    tail_byte = 8'hE5;
            3'd5:    tail_byte = 8'h7D;
            3'd6:    tail_byte = 8'h90;
            default: tail_byte = 8'h4B;
        endcase
    end

    generate
        if (ALT_MAP) begin : g_alt
            always_comb begin
                case (idx)
                    3'd0:    id_byte = 8'h3B;
                    3'd1:    id_byte = 8'h1C;
                    3'd2:    id_byte = 8'h22;
                    default: id_byte = tail_byte;
                endcase
            end
        end else begin : g_base
            always_comb begin
                case (idx)
                    3'd0:    id_byte = 8'h3A;
                    3'd1:    id_byte = 8'h1C;
                    3'd2:    id_byte = 8'h02;
                    default: id_byte = tail_byte;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter bit ALT_MAP = 1'b0,
    parameter int NIRQ    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err,
    input  logic [NIRQ-1:0]   irq_evt,
    output logic              pal_sel,
    output logic              pal_we,
    output logic [PAL_IW-1:0] pal_idx,
    output logic [DW-1:0]     pal_wdata,
    input  logic [DW-1:0]     pal_rdata,
    output logic              irq,
    output logic              lcd_on,
    output logic [2:0]        depth_mode,
    output logic              bgr_order,
    output logic              be_bytes,
    output logic              be_pixels,
    output logic [GEO_W-1:0]  active_cols,
    output logic [GEO_W-1:0]  active_rows,
    output logic [DW-1:0]     upper_base,
    output logic [DW-1:0]     lower_base
);

    typedef struct packed {
        logic [3:0][DW-1:0] timing;
        logic [DW-1:0]      upbase;
        logic [DW-1:0]      lpbase;
        logic [DW-1:0]      ctrl;
        logic [NIRQ-1:0]    mask;
        logic [NIRQ-1:0]    raw;
        logic [DW-1:0]      rdata;
        logic               err;
    } regs_t;

    regs_t            state_d, state_q;
    acc_dec_t         dec;
    logic [7:0]       id_byte;
    logic [DW-1:0]    rd_val;
    logic [NIRQ-1:0]  clr_bits;
    logic             wr_acc, rd_acc;
    logic             addr_unused;

    assign addr_unused = ^bus_addr[1:0];

    lcdc_decode #(.ALT_MAP(ALT_MAP)) u_decode (
        .word (bus_addr[AW-1:2]),
        .dec  (dec)
    );

    lcdc_id_rom #(.ALT_MAP(ALT_MAP)) u_id_rom (
        .idx     (dec.sub),
        .id_byte (id_byte)
    );

    lcdc_geometry u_geometry (
        .col_field (state_q.timing[0][7:2]),
        .row_field (state_q.timing[1][ROWF_W-1:0]),
        .cols      (active_cols),
        .rows      (active_rows)
    );

    assign wr_acc = bus_sel &&  bus_we;
    assign rd_acc = bus_sel && !bus_we;

    always_comb begin
        state_d       = state_q;
        state_d.rdata = '0;
        state_d.err   = 1'b0;
        rd_val        = '0;
        clr_bits      = '0;
        case (dec.kind)
            KIND_TIMING: begin
                rd_val = state_q.timing[dec.sub[1:0]];
                if (wr_acc) state_d.timing[dec.sub[1:0]] = bus_wdata;
            end
            KIND_UPBASE: begin
                rd_val = state_q.upbase;
                if (wr_acc) state_d.upbase = bus_wdata;
            end
            KIND_LPBASE: begin
                rd_val = state_q.lpbase;
                if (wr_acc) state_d.lpbase = bus_wdata;
            end
            KIND_MASK: begin
                rd_val = DW'(state_q.mask);
                if (wr_acc) state_d.mask = bus_wdata[NIRQ-1:0];
            end
            KIND_CTRL: begin
                rd_val = state_q.ctrl;
                if (wr_acc) state_d.ctrl = bus_wdata;
            end
            KIND_RAW:    rd_val = DW'(state_q.raw);
            KIND_MASKED: rd_val = DW'(state_q.raw & state_q.mask);
            KIND_CLEAR: begin
                if (wr_acc) clr_bits = bus_wdata[NIRQ-1:0];
            end
            KIND_UPCUR:  rd_val = state_q.upbase;
            KIND_LPCUR:  rd_val = state_q.lpbase;
            KIND_PAL:    rd_val = pal_rdata;
            KIND_ID:     rd_val = DW'(id_byte);
            default:     state_d.err = bus_sel;
        endcase
        state_d.raw = (state_q.raw & ~clr_bits) | irq_evt;
        if (rd_acc) state_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_rdata  = state_q.rdata;
    assign bus_err    = state_q.err;
    assign pal_sel    = bus_sel && (dec.kind == KIND_PAL);
    assign pal_we     = pal_sel && bus_we;
    assign pal_idx    = bus_addr[PAL_IW+1:2];
    assign pal_wdata  = bus_wdata;
    assign irq        = |(state_q.raw & state_q.mask);
    assign lcd_on     = state_q.ctrl[CTL_EN] & state_q.ctrl[CTL_PWR];
    assign depth_mode = state_q.ctrl[CTL_DLSB+2:CTL_DLSB];
    assign bgr_order  = state_q.ctrl[CTL_BGR];
    assign be_bytes   = state_q.ctrl[CTL_BEB];
    assign be_pixels  = state_q.ctrl[CTL_BEP];
    assign upper_base = state_q.upbase;
    assign lower_base = state_q.lpbase;

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !(bus_sel && dec.kind == KIND_NONE)) |=> !bus_err); // R11

    AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && dec.kind == KIND_NONE) |=>
            ($stable(upper_base) && $stable(lower_base) && $stable(lcd_on) && $stable(active_cols))); // R11

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && dec.kind == KIND_CLEAR) |=>
            ((state_q.raw & $past(bus_wdata[NIRQ-1:0]) & ~$past(irq_evt)) == '0)); // R7

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && dec.kind == KIND_CLEAR) |=>
            ((state_q.raw & $past(state_q.raw)) == $past(state_q.raw))); // R6

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (state_q.mask != '0)); // R6

    AST_COLS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && dec.kind == KIND_TIMING && dec.sub[1:0] == 2'd0) |=>
            (active_cols == {(7'($past(bus_wdata[7:2])) + 7'd1), 4'b0000})); // R4

    AST_ON_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_on |-> state_q.ctrl[CTL_PWR]); // R5

    AST_RO_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && (dec.kind == KIND_UPCUR || dec.kind == KIND_LPCUR)) |=>
            ($stable(upper_base) && $stable(lower_base))); // R8

endmodule

// File: tb/lcdc_regs_bench.sv
module lcdc_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 4;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, pal_rdata = '0;
    logic [3:0]  irq_evt = '0;

    logic [31:0] rdata [2];
    logic        err [2], psel [2], pwe [2], irq_o [2], on_o [2];
    logic        bgr_o [2], beb_o [2], bep_o [2];
    logic [6:0]  pidx [2];
    logic [31:0] pwd [2], ub_o [2], lb_o [2];
    logic [2:0]  dep_o [2];
    logic [10:0] cols_o [2], rows_o [2];

    int n_checks = 0, n_fail = 0;

    logic [31:0] m_tim [4];
    logic [31:0] m_ub, m_lb;
    logic [31:0] m_ctl [2];
    logic [3:0]  m_msk [2];
    logic [3:0]  m_raw;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdc_regs #(.ALT_MAP(1'b0), .NIRQ(NIRQ)) u_lcdc_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata[0]),
        .bus_err(err[0]), .irq_evt(irq_evt), .pal_sel(psel[0]), .pal_we(pwe[0]),
        .pal_idx(pidx[0]), .pal_wdata(pwd[0]), .pal_rdata(pal_rdata),
        .irq(irq_o[0]), .lcd_on(on_o[0]), .depth_mode(dep_o[0]),
        .bgr_order(bgr_o[0]), .be_bytes(beb_o[0]), .be_pixels(bep_o[0]),
        .active_cols(cols_o[0]), .active_rows(rows_o[0]),
        .upper_base(ub_o[0]), .lower_base(lb_o[0])
    );

    lcdc_regs #(.ALT_MAP(1'b1), .NIRQ(NIRQ)) u_lcdc_regs_alt (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata[1]),
        .bus_err(err[1]), .irq_evt(irq_evt), .pal_sel(psel[1]), .pal_we(pwe[1]),
        .pal_idx(pidx[1]), .pal_wdata(pwd[1]), .pal_rdata(pal_rdata),
        .irq(irq_o[1]), .lcd_on(on_o[1]), .depth_mode(dep_o[1]),
        .bgr_order(bgr_o[1]), .be_bytes(beb_o[1]), .be_pixels(bep_o[1]),
        .active_cols(cols_o[1]), .active_rows(rows_o[1]),
        .upper_base(ub_o[1]), .lower_base(lb_o[1])
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] id_ref(int v, logic [2:0] k);
        logic [7:0] base [8] = '{8'h3A, 8'h1C, 8'h02, 8'h00, 8'hE5, 8'h7D, 8'h90, 8'h4B};
        logic [7:0] alt  [8] = '{8'h3B, 8'h1C, 8'h22, 8'h00, 8'hE5, 8'h7D, 8'h90, 8'h4B};
        return (v == 0) ? base[k] : alt[k];
    endfunction

    function automatic bit is_pal(logic [11:0] a);
        return a >= 12'h200 && a <= 12'h3FF;
    endfunction

    function automatic bit is_id(logic [11:0] a);
        return a >= 12'hFE0;
    endfunction

    function automatic bit is_undef(logic [11:0] a);
        return !is_pal(a) && !is_id(a) && (a[11:2] > 10'd12);
    endfunction

    function automatic string tag_of(logic [11:0] a);
        int w = int'(a[11:2]);
        if (is_pal(a)) return "R10";
        if (is_id(a)) return "R9";
        if (is_undef(a)) return "R11";
        if (w <= 5) return "R2";
        if (w <= 7) return "R3";
        if (w <= 9) return "R6";
        if (w == 10) return "R7";
        return "R8";
    endfunction

    function automatic logic [31:0] read_ref(int v, logic [11:0] a, logic [31:0] p);
        int w = int'(a[11:2]);
        if (is_pal(a)) return p;
        if (is_id(a)) return {24'b0, id_ref(v, a[4:2])};
        case (w)
            0, 1, 2, 3: return m_tim[w];
            4, 11:      return m_ub;
            5, 12:      return m_lb;
            6:          return (v == 0) ? {28'b0, m_msk[v]} : m_ctl[v];
            7:          return (v == 0) ? m_ctl[v] : {28'b0, m_msk[v]};
            8:          return {28'b0, m_raw};
            9:          return {28'b0, m_raw & m_msk[v]};
            default:    return '0;
        endcase
    endfunction

    task automatic write_ref(int v, logic [11:0] a, logic [31:0] d);
        int w = int'(a[11:2]);
        if (is_pal(a) || is_id(a)) return;
        case (w)
            0, 1, 2, 3: m_tim[w] = d;
            4: m_ub = d;
            5: m_lb = d;
            6: if (v == 0) m_msk[v] = d[3:0]; else m_ctl[v] = d;
            7: if (v == 0) m_ctl[v] = d; else m_msk[v] = d[3:0];
            default: ;
        endcase
    endtask

    task automatic op(bit s, bit w, logic [11:0] a, logic [31:0] d,
                      logic [3:0] e, logic [31:0] p);
        logic [31:0] exp_rd [2];
        logic [3:0]  clr;
        string       t;
        t = tag_of(a);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
        irq_evt = e; pal_rdata = p;
        #1;
        for (int v = 0; v < 2; v++) begin
            chk("R10", "pal_sel", {31'b0, psel[v]}, {31'b0, s && is_pal(a)});
            chk("R10", "pal_we", {31'b0, pwe[v]}, {31'b0, s && w && is_pal(a)});
            if (s && is_pal(a)) begin
                chk("R10", "pal_idx", {25'b0, pidx[v]}, {25'b0, a[8:2]});
                chk("R10", "pal_wdata", pwd[v], d);
            end
            exp_rd[v] = (s && !w) ? read_ref(v, a, p) : 32'h0;
        end
        clr = (s && w && a[11:2] == 10'd10) ? d[3:0] : 4'h0;
        @(posedge clk);
        if (s && w) begin
            write_ref(0, a, d);
            write_ref(1, a, d);
        end
        m_raw = (m_raw & ~clr) | e;
        #1;
        for (int v = 0; v < 2; v++) begin
            chk(t, "rdata", rdata[v], exp_rd[v]);
            chk("R11", "err", {31'b0, err[v]}, {31'b0, s && is_undef(a)});
            chk("R4", "cols", {21'b0, cols_o[v]}, ((m_tim[0] & 32'hFC) + 32'd4) * 32'd4);
            chk("R4", "rows", {21'b0, rows_o[v]}, (m_tim[1] & 32'h3FF) + 32'd1);
            chk("R5", "lcd_on", {31'b0, on_o[v]}, {31'b0, m_ctl[v][0] & m_ctl[v][11]});
            chk("R5", "ctrl_fields", {26'b0, dep_o[v], bgr_o[v], beb_o[v], bep_o[v]},
                {26'b0, m_ctl[v][3:1], m_ctl[v][8], m_ctl[v][9], m_ctl[v][10]});
            chk("R6", "irq", {31'b0, irq_o[v]}, {31'b0, |(m_raw & m_msk[v])});
            chk("R2", "bases", ub_o[v] ^ {lb_o[v][15:0], lb_o[v][31:16]},
                m_ub ^ {m_lb[15:0], m_lb[31:16]});
        end
        @(negedge clk);
    endtask

    task automatic rd(logic [11:0] a);
        op(1'b1, 1'b0, a, 32'h0, 4'h0, 32'hA5A5_0F0F);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        op(1'b1, 1'b1, a, d, 4'h0, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] a;
        void'($urandom(32'h1CD0_2024));
        for (int i = 0; i < 4; i++) m_tim[i] = '0;
        m_ub = '0; m_lb = '0; m_raw = '0;
        m_ctl[0] = '0; m_ctl[1] = '0; m_msk[0] = '0; m_msk[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle cycle straight after reset
        op(1'b0, 1'b0, 12'h0, 32'h0, 4'h0, 32'h0);
        chk("R1", "cols_reset", {21'b0, cols_o[0]}, 32'd16);
        chk("R1", "rows_reset", {21'b0, rows_o[1]}, 32'd1);
        rd(12'h01C);

        // R4: geometry extremes
        wr(12'h000, 32'hFFFF_FFFF);
        chk("R4", "cols_max", {21'b0, cols_o[0]}, 32'd1024);
        wr(12'h000, 32'h0000_0003);
        wr(12'h000, 32'h0000_0040);
        wr(12'h004, 32'h0000_03FF);
        chk("R4", "rows_max", {21'b0, rows_o[0]}, 32'd1024);
        wr(12'h004, 32'hFFFF_FC00);
        wr(12'h004, 32'h0000_0005);
        wr(12'h008, 32'h1234_5678);
        wr(12'h00C, 32'h9ABC_DEF0);
        rd(12'h008); rd(12'h00C);

        // R2, R8: bases and read-only mirrors
        wr(12'h010, 32'h8000_1000);
        wr(12'h014, 32'h4000_2000);
        wr(12'h02C, 32'hDEAD_BEEF);
        wr(12'h030, 32'hDEAD_BEEF);
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h024, 32'hFFFF_FFFF);
        rd(12'h02C); rd(12'h030);

        // R3, R5: variant swap and control bits
        wr(12'h01C, 32'h0000_0801);
        chk("R3", "swap_on", {30'b0, on_o[1], on_o[0]}, 32'd1);
        wr(12'h01C, 32'h0000_0001);
        wr(12'h01C, 32'h0000_070B);
        wr(12'h018, 32'h0000_0801);
        rd(12'h018); rd(12'h01C);

        // R6, R7: events, mask, clear racing an event
        op(1'b0, 1'b0, 12'h0, 32'h0, 4'b0101, 32'h0);
        wr(12'h018, 32'h0000_0004);
        wr(12'h01C, 32'h0000_0001);
        rd(12'h020); rd(12'h024);
        op(1'b1, 1'b1, 12'h028, 32'h0000_000F, 4'b0001, 32'h0);
        chk("R7", "raw_after_race", {28'b0, m_raw}, 32'd1);
        rd(12'h020); rd(12'h028);

        // R9: identification window, writes ignored
        for (int k = 0; k < 8; k++) rd(12'hFE0 + 12'(k * 4));
        wr(12'hFE4, 32'hFFFF_FFFF);
        rd(12'hFE4);

        // R10, R11: palette window and undefined space
        op(1'b1, 1'b1, 12'h3FC, 32'h0BAD_F00D, 4'h0, 32'h0);
        rd(12'h200);
        wr(12'h034, 32'hFFFF_FFFF);
        rd(12'h034);
        wr(12'hFDC, 32'hFFFF_FFFF);
        rd(12'h400);

        for (int i = 0; i < N_RANDOM; i++) begin
            case ($urandom % 8)
                0, 1, 2, 3: a = 12'(($urandom % 13) * 4);
                4:          a = 12'h200 + 12'(($urandom % 128) * 4);
                5:          a = 12'hFE0 + 12'(($urandom % 8) * 4);
                6:          a = 12'h034 + 12'(($urandom % 115) * 4);
                default:    a = 12'($urandom);
            endcase
            op(($urandom % 8) != 0, $urandom % 2, a, $urandom,
               (($urandom % 6) == 0) ? 4'($urandom) : 4'h0, $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule